// File: doc/BRIEF.md
# Flash Temporary Page Buffer

This block holds one page of instruction words while a self-programming routine assembles new flash contents. Each load strobe stores a 16-bit word, built from a high byte and a low byte, into the slot selected by the word-in-page field of a byte pointer. The lowest pointer bit selects a byte and is ignored for loads. Slots may be filled in any order. A slot accepts a single write between clears. A slot that has not been written reads back as the erased value 0xFFFF.

The whole buffer is discarded when a page write completes, when the read-section re-enable command is issued, when an EEPROM write happens, and on reset. When a page erase or page write starts, the page-number field of the pointer is captured, so software may reuse the pointer afterwards. A flash write engine reads the assembled page through a random-access readout port and takes the captured page number from its own output. Starting an operation does not touch the buffer contents. Loading before the erase and loading after it therefore give the same page.

Top module: `flash_page_buffer`

## Requirements
- R1: After reset, every slot reads 0xFFFF on `rd_word` and `pg_addr` is 0. Asserting `rst_n` at any time brings the block back to this state.
- R2: A load strobe stores `{ld_hi, ld_lo}` into slot `ptr[7:1]`. With the default parameters the slot is visible on `rd_word` from the clock edge that sampled the strobe. `ptr[0]` and the page field `ptr[15:8]` have no effect on which slot is written.
- R3: Slots may be loaded in any order. A load changes only the addressed slot.
- R4: A second load to a slot that is already written is ignored. The first value stays until the buffer is cleared.
- R5: A `wr_done` pulse empties the buffer: every slot reads 0xFFFF and can be loaded again.
- R6: A `reen_stb` pulse empties the buffer in the same way as R5.
- R7: An `ee_wr` pulse empties the buffer in the same way as R5.
- R8: When a clear event (R5 to R7) and a load fall in the same cycle, the clear wins. The loaded word is dropped and the slot reads 0xFFFF.
- R9: An `op_stb` pulse captures `ptr[15:8]` into `pg_addr`. Later pointer changes and loads leave `pg_addr` unchanged until the next `op_stb`.
- R10: `op_stb` leaves the buffer contents unchanged. The same loads give the same page whether they come before or after the erase operation is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| ptr | input | 16 | Byte pointer: page field in bits 15:8, word slot in bits 7:1, byte select in bit 0 |
| ld_stb | input | 1 | Load one word into the slot addressed by `ptr` |
| ld_hi | input | 8 | High byte of the word being loaded |
| ld_lo | input | 8 | Low byte of the word being loaded |
| op_stb | input | 1 | Start of a page erase or page write; captures the page field |
| wr_done | input | 1 | Page write finished; clears the buffer |
| reen_stb | input | 1 | Read-section re-enable command; clears the buffer |
| ee_wr | input | 1 | EEPROM write event; clears the buffer |
| rd_idx | input | 7 | Slot selected on the readout port |
| rd_word | output | 16 | Contents of slot `rd_idx`, or 0xFFFF if that slot is unwritten |
| pg_addr | output | 8 | Page number captured by the last `op_stb` |

## Verification
A load and a clear event can arrive in the same cycle. The bench provokes this by raising `ld_stb` together with `wr_done`, and separately together with `ee_wr`, on a slot that is still unwritten. It then reads that slot and an earlier slot through `rd_idx`. The run is judged correct only if both slots read 0xFFFF and a later load to the same slot is accepted. A load and `op_stb` can also share a cycle. The bench judges that case by checking that the word is stored and that the captured page matches the pointer of that cycle.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  typedef logic [WORD_W-1:0] word_t;
  localparam word_t ERASED_WORD = '1;

  // Events that discard the buffer, kept as a struct so the top can OR them in one place.
  typedef struct packed {
    logic wr_done;
    logic reen;
    logic ee_wr;
  } clr_src_t;

  function automatic logic any_clear(input clr_src_t s);
    return s.wr_done | s.reen | s.ee_wr;
  endfunction
endpackage

// File: rtl/fpb_rst_sync.sv
module fpb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/fpb_ptr_split.sv
module fpb_ptr_split #(
  parameter int PTR_W = 16,
  parameter int IDX_W = 7,
  localparam int PG_W = PTR_W - 1 - IDX_W
) (
  input  logic [PTR_W-1:0] ptr,
  output logic [IDX_W-1:0] slot,
  output logic [PG_W-1:0]  page
);
  // Bit 0 picks a byte and plays no part in word addressing.
  logic unused_byte_sel;
  assign unused_byte_sel = ptr[0];
  assign slot = ptr[IDX_W:1];
  assign page = ptr[PTR_W-1:IDX_W+1];
endmodule

// File: rtl/fpb_page_latch.sv
module fpb_page_latch #(
  parameter int PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic [PG_W-1:0] pg_in,
  output logic [PG_W-1:0] pg_q
);
  logic [PG_W-1:0] pg_d;

  always_comb begin
    pg_d = pg_q;
    if (cap) pg_d = pg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= '0;
    else        pg_q <= pg_d;
  end

  a_r9_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(pg_q));
  a_r9_page_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> pg_q == $past(pg_in));
endmodule

// File: rtl/fpb_word_store.sv
module fpb_word_store
  import fpb_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             clr,
  input  logic [IDX_W-1:0] widx,
  input  word_t            wdata,
  input  logic [IDX_W-1:0] ridx,
  output word_t            rdata
);
  word_t            mem [WORDS];
  logic [WORDS-1:0] filled_q;
  logic [WORDS-1:0] filled_d;
  logic             wr_ok;
  word_t            cur_word;

  // A load lands only on an empty slot and only when no clear arrives with it.
  assign wr_ok    = we & ~clr & ~filled_q[widx];
  assign cur_word = mem[widx];

  for (genvar i = 0; i < WORDS; i++) begin : g_slot
    always_comb begin
      filled_d[i] = filled_q[i];
      if (clr)                                   filled_d[i] = 1'b0;
      else if (we && (widx == IDX_W'(i)))        filled_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filled_q[i] <= 1'b0;
      else        filled_q[i] <= filled_d[i];
    end
  end

  // Data array has no reset: the fill flags decide what is visible.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[widx] <= wdata;
  end

  assign rdata = filled_q[ridx] ? mem[ridx] : ERASED_WORD;

  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (filled_q == '0));
  a_r2_load_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> filled_q[$past(widx)]);
  a_r4_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr && filled_q[widx]) |=> (mem[$past(widx)] == $past(cur_word)));
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we && clr) |=> !filled_q[$past(widx)]);
endmodule

// File: rtl/flash_page_buffer.sv
module flash_page_buffer
  import fpb_pkg::*;
#(
  parameter int PAGE_WORDS = 128,
  parameter int PTR_W      = 16,
  localparam int IDX_W = $clog2(PAGE_WORDS),
  localparam int PG_W  = PTR_W - 1 - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ptr,
  input  logic             ld_stb,
  input  logic [7:0]       ld_hi,
  input  logic [7:0]       ld_lo,
  input  logic             op_stb,
  input  logic             wr_done,
  input  logic             reen_stb,
  input  logic             ee_wr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_word,
  output logic [PG_W-1:0]  pg_addr
);
  logic             rst_sn;
  logic [IDX_W-1:0] slot;
  logic [PG_W-1:0]  page;
  clr_src_t         clr_src;
  logic             clr;
  word_t            wdata;

  fpb_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_sn(rst_sn)
  );

  fpb_ptr_split #(.PTR_W(PTR_W), .IDX_W(IDX_W)) u_split (
    .ptr (ptr),
    .slot(slot),
    .page(page)
  );

  assign clr_src = '{wr_done: wr_done, reen: reen_stb, ee_wr: ee_wr};
  assign clr     = any_clear(clr_src);
  assign wdata   = {ld_hi, ld_lo};

  fpb_word_store #(.WORDS(PAGE_WORDS)) u_store (
    .clk  (clk),
    .rst_n(rst_sn),
    .we   (ld_stb),
    .clr  (clr),
    .widx (slot),
    .wdata(wdata),
    .ridx (rd_idx),
    .rdata(rd_word)
  );

  fpb_page_latch #(.PG_W(PG_W)) u_page (
    .clk  (clk),
    .rst_n(rst_sn),
    .cap  (op_stb),
    .pg_in(page),
    .pg_q (pg_addr)
  );

  a_r7_ee_clears: assert property (@(posedge clk) disable iff (!rst_sn)
    ee_wr |=> (rd_word == ERASED_WORD) || $changed(rd_idx) || ld_stb);
endmodule

// File: tb/tb_flash_page_buffer.sv
module tb_flash_page_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ptr;
  logic        ld_stb, op_stb, wr_done, reen_stb, ee_wr;
  logic [7:0]  ld_hi, ld_lo;
  logic [6:0]  rd_idx;
  logic [15:0] rd_word;
  logic [7:0]  pg_addr;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  flash_page_buffer dut (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .ld_stb(ld_stb), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .op_stb(op_stb), .wr_done(wr_done), .reen_stb(reen_stb), .ee_wr(ee_wr),
    .rd_idx(rd_idx), .rd_word(rd_word), .pg_addr(pg_addr)
  );

  typedef struct packed {
    logic        ld;
    logic [15:0] p;
    logic [15:0] dat;
    logic [6:0]  idx;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  // R2 slot from ptr[7:1]; R3 any order; R4 write-once; R1 unwritten reads 0xFFFF
  localparam vec_t VEC [0:6] = '{
    '{1'b1, 16'h0004, 16'hA1B2, 7'd2,   16'hA1B2, 4'd2},
    '{1'b1, 16'h00FF, 16'h1234, 7'd127, 16'h1234, 4'd2},
    '{1'b1, 16'h0001, 16'h5555, 7'd0,   16'h5555, 4'd3},
    '{1'b1, 16'h0005, 16'hDEAD, 7'd2,   16'hA1B2, 4'd4},
    '{1'b1, 16'h3A10, 16'h0F0F, 7'd8,   16'h0F0F, 4'd2},
    '{1'b0, 16'h0000, 16'h0000, 7'd3,   16'hFFFF, 4'd1},
    '{1'b0, 16'h0000, 16'h0000, 7'd127, 16'h1234, 4'd3}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] idx, input string req, input logic [15:0] exp);
    rd_idx = idx;
    #1;
    chk(req, rd_word, exp);
  endtask

  task automatic load(input logic [15:0] p, input logic [15:0] d);
    @(negedge clk);
    ptr = p; ld_hi = d[15:8]; ld_lo = d[7:0]; ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic pulse_clr(input int which);
    @(negedge clk);
    wr_done = (which == 0); reen_stb = (which == 1); ee_wr = (which == 2);
    @(negedge clk);
    wr_done = 1'b0; reen_stb = 1'b0; ee_wr = 1'b0;
  endtask

  task automatic start_op(input logic [15:0] p);
    @(negedge clk);
    ptr = p; op_stb = 1'b1;
    @(negedge clk);
    op_stb = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] page_a [4];
    rst_n = 1'b0; ptr = '0; ld_stb = 0; ld_hi = 0; ld_lo = 0; op_stb = 0;
    wr_done = 0; reen_stb = 0; ee_wr = 0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(7'd0, "R1", 16'hFFFF);
    rd(7'd64, "R1", 16'hFFFF);
    total++;
    if (pg_addr !== 8'h00) begin bad++; $display("FAIL R1 pg actual=%h expected=00", pg_addr); end

    for (int i = 0; i < 7; i++) begin
      if (VEC[i].ld) load(VEC[i].p, VEC[i].dat);
      rd(VEC[i].idx, $sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp);
    end

    // R5 page write done clears, slot reloadable
    pulse_clr(0);
    rd(7'd2, "R5", 16'hFFFF);
    rd(7'd127, "R5", 16'hFFFF);
    load(16'h0004, 16'hBEEF);
    rd(7'd2, "R5 reload", 16'hBEEF);

    // R6 re-enable clears
    pulse_clr(1);
    rd(7'd2, "R6", 16'hFFFF);

    // R7 EEPROM write clears
    load(16'h0010, 16'h7777);
    pulse_clr(2);
    rd(7'd8, "R7", 16'hFFFF);

    // R8 collision: load with wr_done, then load with ee_wr
    load(16'h0020, 16'h4444);
    @(negedge clk);
    ptr = 16'h0012; ld_hi = 8'h99; ld_lo = 8'h88; ld_stb = 1'b1; wr_done = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0; wr_done = 1'b0;
    rd(7'd9, "R8 wr_done", 16'hFFFF);
    rd(7'd16, "R8 earlier", 16'hFFFF);
    @(negedge clk);
    ptr = 16'h0012; ld_stb = 1'b1; ee_wr = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0; ee_wr = 1'b0;
    rd(7'd9, "R8 ee_wr", 16'hFFFF);
    load(16'h0012, 16'h9988);
    rd(7'd9, "R8 reload", 16'h9988);

    // R9 page capture and hold
    start_op(16'h4501);
    total++;
    if (pg_addr !== 8'h45) begin bad++; $display("FAIL R9 actual=%h expected=45", pg_addr); end
    load(16'h7706, 16'h1111);
    ptr = 16'hFFFF;
    repeat (2) @(negedge clk);
    total++;
    if (pg_addr !== 8'h45) begin bad++; $display("FAIL R9 hold actual=%h expected=45", pg_addr); end
    // load and op_stb in the same cycle
    @(negedge clk);
    ptr = 16'h2C0A; ld_hi = 8'h3C; ld_lo = 8'hC3; ld_stb = 1'b1; op_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0; op_stb = 1'b0;
    total++;
    if (pg_addr !== 8'h2C) begin bad++; $display("FAIL R9 same cycle actual=%h expected=2C", pg_addr); end
    rd(7'd5, "R9 same cycle word", 16'h3CC3);

    // R10 fill before erase versus after erase
    pulse_clr(0);
    load(16'h1000, 16'hAAAA); load(16'h1002, 16'hBBBB);
    start_op(16'h1000);
    for (int i = 0; i < 4; i++) begin rd_idx = 7'(i); #1; page_a[i] = rd_word; end
    pulse_clr(0);
    start_op(16'h1000);
    load(16'h1002, 16'hBBBB); load(16'h1000, 16'hAAAA);
    rd(7'd0, "R10", 16'hAAAA);
    for (int i = 0; i < 4; i++) rd(7'(i), "R10 order", page_a[i]);

    // R1 reset mid-run
    do_reset;
    rd(7'd0, "R1 rerun", 16'hFFFF);
    total++;
    if (pg_addr !== 8'h00) begin bad++; $display("FAIL R1 pg rerun actual=%h expected=00", pg_addr); end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule